// File: doc/BRIEF.md
# Echo Comparator with Post-Echo Masking and Ambient Noise Check

This block sits at the end of an ultrasonic receive path. Each clock it compares the envelope sample from the digital filter with the threshold supplied by the threshold generator. While a measurement window is open, it drives an active-low echo level for as long as the envelope is above that threshold. A registered output feeds the line driver.

Two extra functions guard against false echoes. The first is an optional blanking time after each reported echo. It is counted in drive periods using a one-cycle period tick, and it keeps short ringing from being reported twice. The second is an ambient noise check that runs during the low phase of each send or receive request, before the window opens. That check compares the envelope with a threshold chosen by a 2-bit code and records the result in a sticky flag for the status readout. The first check after reset always uses full scale.

Top module: `echo_cmp_top`

## Requirements
- R1: Inside the measurement window, with masking disabled and no mask running, `echo_n_o` is low in the cycle after a clock edge at which `env_i > thr_i` (strictly greater). It is high after an edge at which `env_i <= thr_i`.
- R2: After any clock edge at which `meas_win_i` is low, `echo_n_o` is high and any running mask is cancelled. The next window starts unmasked.
- R3: With `mask_en_i` high, the end of a reported echo starts a mask. The end of an echo is an edge where the echo was reported and `env_i <= thr_i`. `echo_n_o` then stays high until `MASK_PERIODS` period ticks have been seen at later edges. It may go low again from the edge after the one that consumed the last tick.
- R4: An envelope crossing above the threshold while the mask runs is not reported. It does not restart or extend the mask.
- R5: With `mask_en_i` low, an echo that has just ended can be reported again in the very next cycle.
- R6: After the first noise check, the noise threshold comes from `noise_cfg_i`. Code 00 selects `last_thr_i`, 01 selects 62, 10 selects 124 and 11 selects 620. Noise is an envelope strictly greater than the selected threshold.
- R7: The first noise phase after reset uses the all-ones threshold, so it can never set the flag. Later phases use the configured threshold.
- R8: `noise_flag_o` is cleared at the first cycle of each noise phase and set after any edge in that phase at which noise is seen. It then holds its value until the next noise phase starts.
- R9: After reset, `echo_n_o` is high and `noise_flag_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| env_i | input | ENV_W | Envelope sample from the filter |
| thr_i | input | ENV_W | Threshold from the threshold generator |
| last_thr_i | input | ENV_W | Threshold at the end of the previous window, at unit scale |
| period_tick_i | input | 1 | One-cycle pulse once per drive period |
| mask_en_i | input | 1 | Enables post-echo masking |
| noise_cfg_i | input | 2 | Noise threshold select code |
| noise_phase_i | input | 1 | High during the request low phase (noise check) |
| meas_win_i | input | 1 | High while the measurement window is open |
| echo_n_o | output | 1 | Echo level, low while an echo is reported |
| noise_flag_o | output | 1 | Noise detected in the most recent check |

## Verification
The bench builds the block with a 10-bit envelope and a mask of 4 periods. With 4 periods, every mask step (load, each tick, release, and a crossing during the mask) can be checked in a few cycles. The 10-bit width allows an exhaustive envelope sweep against several thresholds, including 0 and full scale, so the strict greater-than boundary is checked at every value. Each noise code is checked at its threshold and one above it. The all-ones first check is checked with a full-scale envelope.

// File: rtl/echo_cmp_pkg.sv
package echo_cmp_pkg;

  typedef enum logic [1:0] {
    NZ_PREV = 2'b00,
    NZ_LOW  = 2'b01,
    NZ_MID  = 2'b10,
    NZ_HIGH = 2'b11
  } noise_sel_e;

  localparam int unsigned NZ_LOW_VAL  = 62;
  localparam int unsigned NZ_MID_VAL  = 124;
  localparam int unsigned NZ_HIGH_VAL = 620;

endpackage

// File: rtl/echo_mask_unit.sv
module echo_mask_unit #(
  parameter int unsigned ENV_W        = 10,
  parameter int unsigned MASK_PERIODS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ENV_W-1:0] env_i,
  input  logic [ENV_W-1:0] thr_i,
  input  logic             meas_win_i,
  input  logic             period_tick_i,
  input  logic             mask_en_i,
  output logic             echo_n_o
);

  localparam int unsigned CW = $clog2(MASK_PERIODS + 1);
  localparam logic [CW-1:0] MASK_LOAD = CW'(MASK_PERIODS);

  logic          hit;
  logic          rep_q;
  logic [CW-1:0] blank_q;

  assign hit = env_i > thr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_q   <= 1'b0;
      blank_q <= '0;
    end else if (!meas_win_i) begin
      rep_q   <= 1'b0;
      blank_q <= '0;
    end else if (blank_q != '0) begin
      rep_q <= 1'b0;
      if (period_tick_i) blank_q <= blank_q - CW'(1);
    end else if (rep_q && !hit && mask_en_i) begin
      rep_q   <= 1'b0;
      blank_q <= MASK_LOAD;
    end else begin
      rep_q <= hit;
    end
  end

  assign echo_n_o = ~rep_q;

  AST_ECHO_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    !hit |=> echo_n_o); // R1
  AST_IDLE_OUTSIDE_WIN: assert property (@(posedge clk) disable iff (rst)
    !meas_win_i |=> (echo_n_o && blank_q == '0)); // R2
  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (rst)
    (blank_q != '0) |=> echo_n_o); // R4
  AST_MASK_RANGE: assert property (@(posedge clk) disable iff (rst)
    blank_q <= MASK_LOAD); // R3
  AST_MASK_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (blank_q != '0 && meas_win_i) |=> (blank_q <= $past(blank_q))); // R4

endmodule

// File: rtl/noise_chk_unit.sv
module noise_chk_unit
  import echo_cmp_pkg::*;
#(
  parameter int unsigned ENV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ENV_W-1:0] env_i,
  input  logic [ENV_W-1:0] last_thr_i,
  input  logic [1:0]       noise_cfg_i,
  input  logic             noise_phase_i,
  output logic             noise_flag_o
);

  localparam logic [ENV_W-1:0] FULL_SCALE = '1;

  logic [ENV_W-1:0] nthr;
  logic             armed_q;
  logic             phase_q;
  logic             flag_q;
  logic             noisy;

  always_comb begin
    if (!armed_q) begin
      nthr = FULL_SCALE;
    end else begin
      case (noise_sel_e'(noise_cfg_i))
        NZ_PREV: nthr = last_thr_i;
        NZ_LOW:  nthr = ENV_W'(NZ_LOW_VAL);
        NZ_MID:  nthr = ENV_W'(NZ_MID_VAL);
        default: nthr = ENV_W'(NZ_HIGH_VAL);
      endcase
    end
  end

  assign noisy = env_i > nthr;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      phase_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      phase_q <= noise_phase_i;
      if (phase_q && !noise_phase_i) armed_q <= 1'b1;
      if (noise_phase_i && !phase_q) flag_q <= noisy;
      else if (noise_phase_i && noisy) flag_q <= 1'b1;
    end
  end

  assign noise_flag_o = flag_q;

  AST_FIRST_CHECK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> !noise_flag_o); // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !noise_phase_i |=> $stable(noise_flag_o)); // R8
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (noise_phase_i && noisy) |=> noise_flag_o); // R8

endmodule

// File: rtl/echo_cmp_top.sv
module echo_cmp_top #(
  parameter int unsigned ENV_W        = 10,
  parameter int unsigned MASK_PERIODS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ENV_W-1:0] env_i,
  input  logic [ENV_W-1:0] thr_i,
  input  logic [ENV_W-1:0] last_thr_i,
  input  logic             period_tick_i,
  input  logic             mask_en_i,
  input  logic [1:0]       noise_cfg_i,
  input  logic             noise_phase_i,
  input  logic             meas_win_i,
  output logic             echo_n_o,
  output logic             noise_flag_o
);

  echo_mask_unit #(
    .ENV_W       (ENV_W),
    .MASK_PERIODS(MASK_PERIODS)
  ) u_mask (
    .clk          (clk),
    .rst          (rst),
    .env_i        (env_i),
    .thr_i        (thr_i),
    .meas_win_i   (meas_win_i),
    .period_tick_i(period_tick_i),
    .mask_en_i    (mask_en_i),
    .echo_n_o     (echo_n_o)
  );

  noise_chk_unit #(
    .ENV_W(ENV_W)
  ) u_noise (
    .clk          (clk),
    .rst          (rst),
    .env_i        (env_i),
    .last_thr_i   (last_thr_i),
    .noise_cfg_i  (noise_cfg_i),
    .noise_phase_i(noise_phase_i),
    .noise_flag_o (noise_flag_o)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (echo_n_o && !noise_flag_o)); // R9

endmodule

// File: tb/tb_echo_cmp_top.sv
module tb_echo_cmp_top;

  localparam int unsigned W     = 10;
  localparam int unsigned MASKP = 4;
  localparam time CLK_P = 10ns;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] env, thr, last_thr;
  logic         tick, mask_en, nphase, meas;
  logic [1:0]   ncfg;
  logic         echo_n, nflag;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  echo_cmp_top #(.ENV_W(W), .MASK_PERIODS(MASKP)) dut (
    .clk(clk), .rst(rst), .env_i(env), .thr_i(thr), .last_thr_i(last_thr),
    .period_tick_i(tick), .mask_en_i(mask_en), .noise_cfg_i(ncfg),
    .noise_phase_i(nphase), .meas_win_i(meas),
    .echo_n_o(echo_n), .noise_flag_o(nflag)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic noise_probe(input logic [1:0] code, input int unsigned lim);
    ncfg = code; nphase = 1'b1; env = W'(lim);
    step();
    chk("R6 at limit", nflag, 1'b0);
    env = W'(lim + 1);
    step();
    chk("R6 above limit", nflag, 1'b1);
    env = '0; nphase = 1'b0;
    step();
    chk("R8 held after phase", nflag, 1'b1);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; env = '0; thr = '0; last_thr = '0; tick = 1'b0;
    mask_en = 1'b0; nphase = 1'b0; meas = 1'b0; ncfg = 2'b00;
    step(); step();
    rst = 1'b0;
    chk("R9 echo idle", echo_n, 1'b1);
    chk("R9 flag clear", nflag, 1'b0);

    // R7: first noise phase uses full scale
    nphase = 1'b1; ncfg = 2'b01; env = '1;
    step(); step();
    chk("R7 first check quiet", nflag, 1'b0);
    nphase = 1'b0; env = '0;
    step();

    // R1: exhaustive envelope sweep, mask disabled
    meas = 1'b1;
    foreach (thr_list[i]) begin
      thr = thr_list[i];
      for (int e = 0; e < (1 << W); e++) begin
        env = W'(e);
        step();
        chk("R1 compare", echo_n, !(W'(e) > thr_list[i]));
      end
    end

    // R2: outside window
    meas = 1'b0; thr = '0; env = '1;
    step();
    chk("R2 idle outside window", echo_n, 1'b1);

    // R5: no masking
    meas = 1'b1; thr = 10'd100; env = 10'd200;
    step(); chk("R5 echo on", echo_n, 1'b0);
    env = 10'd50;
    step(); chk("R5 echo off", echo_n, 1'b1);
    env = 10'd200;
    step(); chk("R5 immediate retrigger", echo_n, 1'b0);

    // R3 / R4: masking
    mask_en = 1'b1;
    env = 10'd200;
    step(); chk("R3 echo before mask", echo_n, 1'b0);
    env = 10'd50;
    step(); chk("R3 fall", echo_n, 1'b1);
    env = 10'd200;
    step(); chk("R4 crossing ignored", echo_n, 1'b1);
    for (int t = 0; t < int'(MASKP); t++) begin
      tick = 1'b1;
      step();
      chk("R4 still masked", echo_n, 1'b1);
      tick = 1'b0;
      step();
      chk(t == int'(MASKP) - 1 ? "R3 released" : "R3 masked",
          echo_n, t == int'(MASKP) - 1 ? 1'b0 : 1'b1);
    end

    // R2: leaving window cancels mask
    env = 10'd50;
    step(); chk("R3 second fall", echo_n, 1'b1);
    meas = 1'b0;
    step(); chk("R2 window closed", echo_n, 1'b1);
    meas = 1'b1; env = 10'd200;
    step(); chk("R2 mask cancelled", echo_n, 1'b0);
    meas = 1'b0; mask_en = 1'b0; env = '0;
    step();

    // R6 / R8: configured noise thresholds
    noise_probe(2'b01, 62);
    nphase = 1'b1; env = '0;
    step(); chk("R8 cleared at phase start", nflag, 1'b0);
    env = 10'd70;
    step(); chk("R8 set in phase", nflag, 1'b1);
    env = '0;
    step(); chk("R8 sticky in phase", nflag, 1'b1);
    nphase = 1'b0;
    step();
    noise_probe(2'b10, 124);
    noise_probe(2'b11, 620);
    last_thr = 10'd300;
    noise_probe(2'b00, 300);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [W-1:0] thr_list [5] = '{10'd0, 10'd62, 10'd500, 10'd1022, 10'd1023};

endmodule